// File: doc/BRIEF.md
# Multi-beat wide load/store sequencer

This block is the memory-access stage of a small in-order core whose general registers are 128 bits wide but whose memory port carries one 32-bit word per transfer. It takes a decoded doubleword or quadword load or store, forms the effective address from a base value and a signed 16-bit displacement, and runs the access as a series of word beats. A single beat counter serves every access width. It steps the word address and picks the register lane to capture or drive. Each access stops at the terminal beat for its width.

Loads go out lane by lane on a 128-bit register write port. Lane 0 is also copied to a 32-bit architectural register file. A doubleword load writes only lanes 0 and 1, so the upper half of the target keeps its value. Stores send the matching lanes of a source value, which is captured at dispatch, with all byte enables set. If an address is misaligned for the access width, the access is dropped before any memory traffic and a load or store address-error code is raised.

Top module: `wide_ls_seq`

## Requirements
- R1: After reset the block is idle: `op_ready_o` is 1, and `mem_req_o`, `rf_we_o`, `arch_we_o`, `done_o` and `exc_o` are 0.
- R2: The effective address is `base_i` plus the sign-extended `offset_i`. Beat k requests word address ea + 4k.
- R3: A doubleword access takes 2 beats and a quadword access takes 4. A beat completes in a cycle where `mem_req_o` and `mem_ready_i` are both high. `done_o` pulses in the cycle the last beat completes, and `op_ready_o` returns in the next cycle.
- R4: Opcode 0x37 (doubleword load): beat 0 writes lane 0 (bits 31:0) and also writes the architectural register. Beat 1 writes lane 1 (bits 63:32). Lanes 2 and 3 are never written.
- R5: Opcode 0x1E (quadword load): beat k writes lane k (bits 32k+31:32k) with the word read at ea + 4k. Only beat 0 writes the architectural register.
- R6: Opcodes 0x3F (doubleword store) and 0x1F (quadword store): beat k drives lane k of `src_i` on `mem_wdata_o` with `mem_be_o` = 4'hF. Stores never write registers. A doubleword store followed by a doubleword load from the same address returns both stored lanes.
- R7: A doubleword access whose ea[2:0] is not 0 makes no memory request. One cycle later `exc_o` pulses with `exc_code_o` = 4 for a load or 5 for a store, and `exc_addr_o` = ea.
- R8: A quadword access whose ea[3:0] is not 0 faults in the same way, with the same codes.
- R9: A load whose target is register 0 writes no register but still performs all of its beats.
- R10: While a beat waits for `mem_ready_i`, the request, address, data and write flag stay unchanged.
- R11: Any other opcode is ignored: no request, no exception, and the block stays ready.
- R12: The instruction word 0xDFBF0000 splits into opcode 0x37, base register 29, target register 31 and offset 0. It runs as a doubleword load into register 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Decoded instruction present |
| op_ready_o | output | 1 | Sequencer idle, can accept |
| opcode_i | input | 6 | Major opcode |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| rt_i | input | 5 | Target/source register index |
| src_i | input | 128 | Source register value for stores |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Byte address of the beat word |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Beat accepted/completed |
| rf_we_o | output | 1 | 128-bit register lane write |
| rf_idx_o | output | 5 | Register index written |
| rf_lane_o | output | 2 | Lane written |
| rf_wdata_o | output | 32 | Lane data |
| arch_we_o | output | 1 | Architectural 32-bit register write |
| arch_wdata_o | output | 32 | Architectural write data |
| done_o | output | 1 | Access retired |
| exc_o | output | 1 | Address-error pulse |
| exc_code_o | output | 5 | 4 = load fault, 5 = store fault |
| exc_addr_o | output | 32 | Faulting effective address |

## Verification
The assertions assume that the memory side completes a beat only while a request is up and holds `mem_rdata_i` valid in the ready cycle. They also assume `op_valid_i` is raised only while `op_ready_o` is high. The bench's memory model derives ready from its own wait counter, gated by the request, with a stall of 0 to 2 cycles. The bench presents each instruction for exactly one cycle while the block is idle. The sweeps cover all four access kinds, every stall length and several aligned addresses, including a base-plus-negative-offset form. They then cover each misaligned residue and a set of opcodes that do not belong to the block.

// File: rtl/wls_pkg.sv
package wls_pkg;
  localparam logic [5:0] OPC_LD = 6'h37;
  localparam logic [5:0] OPC_SD = 6'h3F;
  localparam logic [5:0] OPC_LQ = 6'h1E;
  localparam logic [5:0] OPC_SQ = 6'h1F;

  localparam logic [4:0] EXC_LOAD_ADDR  = 5'd4;
  localparam logic [4:0] EXC_STORE_ADDR = 5'd5;

  typedef enum logic {ST_IDLE, ST_BEAT} seq_state_t;

  typedef struct packed {
    logic hit;
    logic is_load;
    logic is_quad;
  } acc_kind_t;
endpackage

// File: rtl/wls_decode.sv
module wls_decode
  import wls_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [5:0]      opcode_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [15:0]     offset_i,
  output acc_kind_t       kind_o,
  output logic [XLEN-1:0] ea_o,
  output logic            misalign_o
);
  always_comb begin
    kind_o = '0;
    unique case (opcode_i)
      OPC_LD:  kind_o = '{hit: 1'b1, is_load: 1'b1, is_quad: 1'b0};
      OPC_SD:  kind_o = '{hit: 1'b1, is_load: 1'b0, is_quad: 1'b0};
      OPC_LQ:  kind_o = '{hit: 1'b1, is_load: 1'b1, is_quad: 1'b1};
      OPC_SQ:  kind_o = '{hit: 1'b1, is_load: 1'b0, is_quad: 1'b1};
      default: kind_o = '0;
    endcase
  end

  assign ea_o = base_i + {{(XLEN-16){offset_i[15]}}, offset_i};

  // doubleword needs 8-byte, quadword 16-byte alignment
  assign misalign_o = kind_o.is_quad ? (|ea_o[3:0]) : (|ea_o[2:0]);
endmodule

// File: rtl/wls_beat_ctr.sv
module wls_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [BEAT_W-1:0] term_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_o <= '0;
    else if (clear_i) beat_o <= '0;
    else if (step_i)  beat_o <= beat_o + BEAT_W'(1);
  end

  assign last_o = (beat_o == term_i);
endmodule

// File: rtl/wls_lane_mux.sv
module wls_lane_mux #(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  localparam int BEAT_W = $clog2(LANES)
) (
  input  logic [LANES*XLEN-1:0] data_i,
  input  logic [BEAT_W-1:0]     sel_i,
  output logic [XLEN-1:0]       word_o
);
  logic [XLEN-1:0] lane_w [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_w[g] = data_i[g*XLEN +: XLEN];
  end

  assign word_o = lane_w[sel_i];
endmodule

// File: rtl/wide_ls_seq.sv
module wide_ls_seq
  import wls_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REG_W   = 128,
  parameter int IDX_W   = 5,
  localparam int LANES  = REG_W / XLEN,
  localparam int BEAT_W = $clog2(LANES),
  localparam int BE_W   = XLEN / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  output logic              op_ready_o,
  input  logic [5:0]        opcode_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [15:0]       offset_i,
  input  logic [IDX_W-1:0]  rt_i,
  input  logic [REG_W-1:0]  src_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic [BE_W-1:0]   mem_be_o,
  input  logic [XLEN-1:0]   mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_idx_o,
  output logic [BEAT_W-1:0] rf_lane_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              arch_we_o,
  output logic [XLEN-1:0]   arch_wdata_o,
  output logic              done_o,
  output logic              exc_o,
  output logic [4:0]        exc_code_o,
  output logic [XLEN-1:0]   exc_addr_o
);
  localparam logic [BEAT_W-1:0] DW_TERM = BEAT_W'((64 / XLEN) - 1);
  localparam logic [BEAT_W-1:0] QW_TERM = BEAT_W'(LANES - 1);

  seq_state_t        state_q;
  acc_kind_t         dec_kind;
  logic [XLEN-1:0]   dec_ea;
  logic              dec_misalign;
  logic              accept, fault, beat_done;
  logic              is_load_q, is_quad_q;
  logic [XLEN-1:0]   ea_q;
  logic [IDX_W-1:0]  rt_q;
  logic [REG_W-1:0]  src_q;
  logic [BEAT_W-1:0] beat, term;
  logic              last;
  logic [XLEN-1:0]   store_word;

  wls_decode #(.XLEN(XLEN)) u_dec (
    .opcode_i  (opcode_i),
    .base_i    (base_i),
    .offset_i  (offset_i),
    .kind_o    (dec_kind),
    .ea_o      (dec_ea),
    .misalign_o(dec_misalign)
  );

  assign op_ready_o = (state_q == ST_IDLE);
  assign accept     = op_valid_i && op_ready_o && dec_kind.hit && !dec_misalign;
  assign fault      = op_valid_i && op_ready_o && dec_kind.hit && dec_misalign;
  assign beat_done  = (state_q == ST_BEAT) && mem_ready_i;
  assign term       = is_quad_q ? QW_TERM : DW_TERM;

  wls_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(accept),
    .step_i (beat_done && !last),
    .term_i (term),
    .beat_o (beat),
    .last_o (last)
  );

  wls_lane_mux #(.XLEN(XLEN), .LANES(LANES)) u_mux (
    .data_i(src_q),
    .sel_i (beat),
    .word_o(store_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      is_load_q <= 1'b0;
      is_quad_q <= 1'b0;
      ea_q      <= '0;
      rt_q      <= '0;
      src_q     <= '0;
    end else begin
      if (accept) begin
        state_q   <= ST_BEAT;
        is_load_q <= dec_kind.is_load;
        is_quad_q <= dec_kind.is_quad;
        ea_q      <= dec_ea;
        rt_q      <= rt_i;
        src_q     <= src_i;
      end else if (beat_done && last) begin
        state_q <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_o      <= 1'b0;
      exc_code_o <= '0;
      exc_addr_o <= '0;
    end else begin
      exc_o <= fault;
      if (fault) begin
        exc_code_o <= dec_kind.is_load ? EXC_LOAD_ADDR : EXC_STORE_ADDR;
        exc_addr_o <= dec_ea;
      end
    end
  end

  assign mem_req_o   = (state_q == ST_BEAT);
  assign mem_we_o    = mem_req_o && !is_load_q;
  assign mem_addr_o  = ea_q + XLEN'({beat, 2'b00});
  assign mem_wdata_o = mem_we_o ? store_word : '0;
  assign mem_be_o    = mem_req_o ? {BE_W{1'b1}} : '0;

  // loads share one capture path; only the terminal beat differs
  assign rf_we_o      = beat_done && is_load_q && (rt_q != '0);
  assign rf_idx_o     = rt_q;
  assign rf_lane_o    = beat;
  assign rf_wdata_o   = mem_rdata_i;
  assign arch_we_o    = rf_we_o && (beat == '0);
  assign arch_wdata_o = mem_rdata_i;
  assign done_o       = beat_done && last;
endmodule

// File: rtl/wide_ls_seq_chk.sv
module wide_ls_seq_chk #(
  parameter int XLEN   = 32,
  parameter int IDX_W  = 5,
  parameter int BEAT_W = 2,
  parameter int BE_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [XLEN-1:0]   mem_addr_o,
  input logic [XLEN-1:0]   mem_wdata_o,
  input logic [BE_W-1:0]   mem_be_o,
  input logic              mem_ready_i,
  input logic              rf_we_o,
  input logic [IDX_W-1:0]  rf_idx_o,
  input logic [BEAT_W-1:0] rf_lane_o,
  input logic              arch_we_o,
  input logic              done_o,
  input logic              exc_o
);
  a_r10_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i && !done_o |=>
      mem_req_o && (mem_addr_o == $past(mem_addr_o) + XLEN'(4)));

  a_r3_done_on_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mem_req_o && mem_ready_i);

  a_r3_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> op_ready_o && !mem_req_o);

  a_r9_no_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> rf_idx_o != '0);

  a_r4_mirror_lane0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arch_we_o |-> rf_we_o && rf_lane_o == '0);

  a_r6_load_beat_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> mem_req_o && mem_ready_i && !mem_we_o);

  a_r6_full_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> &mem_be_o);

  a_r7_fault_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !mem_req_o && op_ready_o);
endmodule

bind wide_ls_seq wide_ls_seq_chk #(
  .XLEN(XLEN), .IDX_W(IDX_W), .BEAT_W(BEAT_W), .BE_W(BE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_ready_o (op_ready_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_be_o   (mem_be_o),
  .mem_ready_i(mem_ready_i),
  .rf_we_o    (rf_we_o),
  .rf_idx_o   (rf_idx_o),
  .rf_lane_o  (rf_lane_o),
  .arch_we_o  (arch_we_o),
  .done_o     (done_o),
  .exc_o      (exc_o)
);

// File: tb/wide_ls_seq_test.sv
module wide_ls_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] MARK = {4{32'hEEEE_EEEE}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic         op_ready;
  logic [5:0]   opcode = '0;
  logic [31:0]  base = '0;
  logic [15:0]  offset = '0;
  logic [4:0]   rt = '0;
  logic [127:0] src = '0;
  logic         mem_req, mem_we, mem_ready;
  logic [31:0]  mem_addr, mem_wdata, mem_rdata;
  logic [3:0]   mem_be;
  logic         rf_we, arch_we, done, exc;
  logic [4:0]   rf_idx, exc_code;
  logic [1:0]   rf_lane;
  logic [31:0]  rf_wdata, arch_wdata, exc_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int delay = 0;
  int wait_cnt = 0;
  int beats = 0, dones = 0, excs = 0, rf_writes = 0;
  logic [4:0]  last_exc_code;
  logic [31:0] last_exc_addr;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [31:0] mem [64];
  logic [127:0] sh [32];
  logic [31:0]  arch_sh [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_ls_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_ready_o(op_ready),
    .opcode_i(opcode), .base_i(base), .offset_i(offset), .rt_i(rt), .src_i(src),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready), .rf_we_o(rf_we), .rf_idx_o(rf_idx),
    .rf_lane_o(rf_lane), .rf_wdata_o(rf_wdata), .arch_we_o(arch_we),
    .arch_wdata_o(arch_wdata), .done_o(done), .exc_o(exc),
    .exc_code_o(exc_code), .exc_addr_o(exc_addr)
  );

  function automatic logic [31:0] pat(int i);
    return 32'(i) * 32'h9E37_79B9 + 32'h1357;
  endfunction

  assign mem_ready = mem_req && (wait_cnt >= delay);
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_ready) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (mem_req && mem_ready && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ready) beats++;
      if (done) dones++;
      if (exc) begin excs++; last_exc_code = exc_code; last_exc_addr = exc_addr; end
      if (rf_we) begin rf_writes++; sh[rf_idx][rf_lane*32 +: 32] = rf_wdata; end
      if (arch_we) arch_sh[rf_idx] = arch_wdata;
      if (prev_wait && mem_req)
        check(mem_addr == prev_addr, "R10 addr held", 128'(mem_addr), 128'(prev_addr));
      prev_wait = mem_req && !mem_ready;
      prev_addr = mem_addr;
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic fill_mem();
    for (int i = 0; i < 64; i++) mem[i] = pat(i);
  endtask

  task automatic run_op(input logic [5:0] op, input logic [31:0] b, input logic [15:0] off,
                        input logic [4:0] r, input logic [127:0] s);
    @(negedge clk);
    beats = 0; dones = 0; excs = 0; rf_writes = 0;
    sh[r] = MARK; arch_sh[r] = MARK[31:0];
    opcode = op; base = b; offset = off; rt = r; src = s; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (dones != 0 || excs != 0) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] word, ea;
    fill_mem();
    for (int i = 0; i < 32; i++) begin sh[i] = MARK; arch_sh[i] = '0; end
    #(CLK_PERIOD*2 + 1);
    // R1 reset state
    check(op_ready && !mem_req && !rf_we && !arch_we && !done && !exc, "R1 reset",
          128'({op_ready, mem_req, rf_we, arch_we, done, exc}), 128'(6'b100000));
    rst_n = 1'b1;
    @(negedge clk);
    check(op_ready && !mem_req, "R1 idle after reset", 128'({op_ready, mem_req}), 128'(2'b10));

    for (int d = 0; d < 3; d++) begin
      delay = d;
      for (int a = 0; a < 4; a++) begin
        logic [31:0] b;
        logic [15:0] off;
        logic [4:0]  r;
        logic [127:0] s;
        ea  = 32'h40 + 32'(a * 16);
        b   = (a == 3) ? ea + 32'h20 : ea;
        off = (a == 3) ? 16'hFFE0 : 16'h0;  // R2 negative offset
        r   = 5'(1 + a + 4*d);
        s   = {pat(100+a), pat(101+a), pat(102+a), pat(103+a)};

        fill_mem();
        run_op(wls_pkg::OPC_LD, b, off, r, s);
        check(sh[r] == {MARK[127:64], pat(ea/4+1), pat(ea/4)}, "R4 LD lanes",
              sh[r], {MARK[127:64], pat(ea/4+1), pat(ea/4)});
        check(arch_sh[r] == pat(ea/4), "R4 LD arch mirror", 128'(arch_sh[r]), 128'(pat(ea/4)));
        check(beats == 2 && dones == 1, "R3 LD beats", 128'(beats), 128'(2));

        run_op(wls_pkg::OPC_LQ, b, off, r, s);
        check(sh[r] == {pat(ea/4+3), pat(ea/4+2), pat(ea/4+1), pat(ea/4)}, "R5 LQ lanes",
              sh[r], {pat(ea/4+3), pat(ea/4+2), pat(ea/4+1), pat(ea/4)});
        check(arch_sh[r] == pat(ea/4), "R5 LQ arch mirror", 128'(arch_sh[r]), 128'(pat(ea/4)));
        check(beats == 4 && dones == 1, "R3 LQ beats", 128'(beats), 128'(4));

        run_op(wls_pkg::OPC_SD, b, off, r, s);
        word = mem[ea/4+2];
        check({mem[ea/4+1], mem[ea/4]} == s[63:0] && word == pat(ea/4+2), "R6 SD words",
              {word, mem[ea/4+1], mem[ea/4]}, {pat(ea/4+2), s[63:0]});
        check(beats == 2 && rf_writes == 0, "R6 SD no reg write", 128'(rf_writes), 128'(0));

        run_op(wls_pkg::OPC_LD, b, off, 5'(r + 1), '0);
        check(sh[r+1][63:0] == s[63:0], "R6 SD then LD", sh[r+1], {MARK[127:64], s[63:0]});

        run_op(wls_pkg::OPC_SQ, b, off, r, s);
        check({mem[ea/4+3], mem[ea/4+2], mem[ea/4+1], mem[ea/4]} == s, "R6 SQ words",
              {mem[ea/4+3], mem[ea/4+2], mem[ea/4+1], mem[ea/4]}, s);
        check(beats == 4 && dones == 1, "R3 SQ beats", 128'(beats), 128'(4));
      end
    end

    // R7 / R8 misaligned sweep
    delay = 1;
    fill_mem();
    for (int m = 1; m < 16; m++) begin
      ea = 32'h80 + 32'(m);
      if (m % 8 != 0) begin
        run_op(wls_pkg::OPC_LD, ea, 16'h0, 5'd3, '0);
        check(excs == 1 && last_exc_code == 5'd4 && last_exc_addr == ea && beats == 0,
              "R7 LD misalign", {last_exc_code, last_exc_addr, 32'(beats)}, {5'd4, ea, 32'd0});
        run_op(wls_pkg::OPC_SD, ea, 16'h0, 5'd3, '1);
        check(excs == 1 && last_exc_code == 5'd5 && beats == 0, "R7 SD misalign",
              128'(last_exc_code), 128'(5));
      end
      run_op(wls_pkg::OPC_LQ, ea, 16'h0, 5'd3, '0);
      check(excs == 1 && last_exc_code == 5'd4 && beats == 0 && sh[3] == MARK, "R8 LQ misalign",
            128'(last_exc_code), 128'(4));
      run_op(wls_pkg::OPC_SQ, ea, 16'h0, 5'd3, '1);
      check(excs == 1 && last_exc_code == 5'd5 && beats == 0, "R8 SQ misalign",
            128'(last_exc_code), 128'(5));
    end
    check(mem[32] == pat(32) && mem[33] == pat(33), "R7 no store on fault",
          128'(mem[32]), 128'(pat(32)));
    // doubleword on 8-byte boundary is fine for LD but faults for LQ
    run_op(wls_pkg::OPC_LD, 32'h88, 16'h0, 5'd4, '0);
    check(excs == 0 && beats == 2, "R7 LD 8-aligned ok", 128'(beats), 128'(2));
    run_op(wls_pkg::OPC_LQ, 32'h88, 16'h0, 5'd4, '0);
    check(excs == 1 && beats == 0, "R8 LQ 8-aligned faults", 128'(excs), 128'(1));

    // R9 register 0
    run_op(wls_pkg::OPC_LQ, 32'h40, 16'h0, 5'd0, '0);
    check(sh[0] == MARK && rf_writes == 0 && beats == 4, "R9 rt zero",
          {sh[0][127:32], 32'(beats)}, {MARK[127:32], 32'd4});

    // R11 other opcodes
    for (int o = 0; o < 64; o += 5) begin
      if (o == 6'h37 || o == 6'h3F || o == 6'h1E || o == 6'h1F) continue;
      @(negedge clk);
      beats = 0; excs = 0;
      opcode = 6'(o); base = 32'h41; rt = 5'd5; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      check(op_ready && !mem_req, "R11 ignored opcode ready", 128'({op_ready, mem_req}), 128'(2));
      repeat (3) @(negedge clk);
      check(beats == 0 && excs == 0, "R11 ignored opcode", 128'({beats, excs}), 128'(0));
    end

    // R12 instruction word split
    begin
      logic [31:0] iw;
      iw = 32'hDFBF_0000;
      sh[29] = '0;
      mem[16] = 32'hAABB_CCDD; mem[17] = 32'h1122_3344;
      check(iw[31:26] == 6'h37 && iw[25:21] == 5'd29 && iw[20:16] == 5'd31 && iw[15:0] == 0,
            "R12 field split", 128'(iw), 128'(32'hDFBF0000));
      run_op(iw[31:26], 32'h40, iw[15:0], iw[20:16], '0);
      check(sh[31] == {MARK[127:64], 32'h1122_3344, 32'hAABB_CCDD} && arch_sh[31] == 32'hAABB_CCDD,
            "R12 LD into r31", sh[31], {MARK[127:64], 32'h1122_3344, 32'hAABB_CCDD});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule